// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Each word holds four 8-bit bytes plus one parity bit per byte, which gives 36 bits. Reads and writes can follow each other on consecutive clocks with no idle cycle between them.

A command is captured at a rising clock edge. Write data follows one edge after its address. Read data is registered and appears one edge after its address.

A single load/advance control either starts a new access or steps a two-bit burst counter. The counter walks the low two address bits in linear or interleaved order, as chosen by a static strap. A clock-enable input stalls the whole pipeline. An asynchronous output enable gates only the data drivers. The bidirectional bus is split into a write-data input, a read-data output and a drive-enable output.

Top module: `nbt_sram`

## Requirements
- R1: At an enabled edge with `ld_n` low, the device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A selected load captures `addr` and the command: `wr_n`=0 means write and `wr_n`=1 means read. An unselected load deselects the device and performs no access.
- R2: While `clk_en_n` is high, no input is sampled, no write reaches the array, and `rdata`, the burst state and the pending access all hold. After the stall, the pipeline resumes where it stopped.
- R3: Read latency:
  - The word at a read address captured at edge C is on `rdata` after edge C+1.
  - If `oe_n` is low, `rdata_oe` is high in that same cycle.
- R4: Write data and byte lanes:
  - Write data on `wdata` is sampled at the enabled edge that follows the edge capturing the write address.
  - `byte_en_n[i]` low, sampled with the address, writes data bits 8i+7..8i and parity bit 32+i.
  - Lanes whose enable is high keep their old contents.
- R5: A read issued on the clock right after a write to the same address returns the newly written word, with no idle cycle in between.
- R6: With `order_il`=0 (linear), each enabled edge with `ld_n` high advances the burst:
  - The k-th advance after a load accesses offset (start offset + k) mod 4 in the low two address bits. The upper address bits stay fixed.
  - The burst keeps the direction of its load and ignores `wr_n`.
  - `byte_en_n` is sampled again at each advance.
- R7: With `order_il`=1 (interleaved), the k-th advance accesses offset (start offset XOR k), k = 0..3, and the counter wraps after four accesses.
- R8: `rdata_oe` is low in the cycle after any enabled edge whose completing access was not a read. This covers a write data phase, a deselected or idle cycle, and the first cycle after leaving the deselected state.
- R9: `oe_n` high forces `rdata_oe` low combinationally and has no effect on `rdata`.
- R10: After a deselect or reset, an advance (`ld_n` high) is a no-operation: it writes nothing and drives nothing until a selected load occurs.
- R11: After reset, `rdata_oe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls everything |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new address and command; high advances the burst |
| wr_n | input | 1 | Low makes a load a write, high a read |
| byte_en_n | input | NBYTES | Active-low byte lane write enables |
| addr | input | ADDR_W | Word address |
| order_il | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | NBYTES*(BYTE_W+1) | Write data; parity bits sit above the data bytes |
| rdata | output | NBYTES*(BYTE_W+1) | Registered read data |
| rdata_oe | output | 1 | High when the read data should drive the bus |

## Verification
The assertions check the control invariants on every clock:
- stalls freeze the output register and the pending command;
- the chip-select decode either loads or idles;
- an advance from idle stays idle;
- a non-read completion never drives;
- a high output enable always blocks the drive.

Data coherence needs the bench's scenarios, which compare against a behavioural memory model. These scenarios cover back-to-back write/read pairs, merges of partial byte lanes, wrapping bursts in both orders, writes attempted from the idle state and stalls in the middle of an access.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;
   // operation held in the command stage
   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2
   } op_e;
endpackage

// File: rtl/nbt_burst_ctr.sv
`timescale 1ns/1ps
// Command stage: decodes load/advance, keeps the burst base and step,
// and presents one registered access per enabled edge.
module nbt_burst_ctr #(
   parameter int ADDR_W = 10,
   parameter int NBYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 sel,
   input  logic                 ld_n,
   input  logic                 wr_n,
   input  logic [NBYTES-1:0]    be_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 order_il,
   output nbt_pkg::op_e         cmd_op,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic [NBYTES-1:0]    cmd_be_n
);
   import nbt_pkg::*;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        step_q;
   logic [1:0]        step_nx;
   logic [1:0]        off_nx;
   logic              bwr_q;
   logic              active_q;
   logic [ADDR_W-1:0] adv_addr;

   assign step_nx = step_q + 2'd1;
   assign off_nx  = order_il ? (base_q[1:0] ^ step_nx) : (base_q[1:0] + step_nx);

   generate
      if (ADDR_W == 2) begin : g_narrow
         assign adv_addr = off_nx;
      end else begin : g_wide
         assign adv_addr = {base_q[ADDR_W-1:2], off_nx};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         step_q   <= '0;
         bwr_q    <= 1'b0;
         active_q <= 1'b0;
         cmd_op   <= OP_NOP;
         cmd_addr <= '0;
         cmd_be_n <= '1;
      end else if (en) begin
         cmd_be_n <= be_n;
         if (!ld_n) begin
            if (sel) begin
               base_q   <= addr;
               step_q   <= 2'd0;
               bwr_q    <= ~wr_n;
               active_q <= 1'b1;
               cmd_op   <= wr_n ? OP_RD : OP_WR;
               cmd_addr <= addr;
            end else begin
               active_q <= 1'b0;
               cmd_op   <= OP_NOP;
            end
         end else if (active_q) begin
            step_q   <= step_nx;
            cmd_op   <= bwr_q ? OP_WR : OP_RD;
            cmd_addr <= adv_addr;
         end else begin
            cmd_op   <= OP_NOP;
         end
      end
   end
endmodule

// File: rtl/nbt_array.sv
`timescale 1ns/1ps
// Storage with byte-lane write merge and the registered read port.
module nbt_array #(
   parameter int ADDR_W = 10,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            en,
   input  nbt_pkg::op_e                    op,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [NBYTES-1:0]               be_n,
   input  logic [NBYTES*(BYTE_W+1)-1:0]    wdata,
   output logic [NBYTES*(BYTE_W+1)-1:0]    rdata,
   output logic                            rd_valid
);
   import nbt_pkg::*;

   localparam int WORD_W = NBYTES * (BYTE_W + 1);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAR_LO = NBYTES * BYTE_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] lane_mask;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_lane
         assign lane_mask[BYTE_W*i +: BYTE_W] = {BYTE_W{~be_n[i]}};
         assign lane_mask[PAR_LO + i]         = ~be_n[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en && op == OP_WR) begin
         mem[addr] <= (mem[addr] & ~lane_mask) | (wdata & lane_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else if (en) begin
         rd_valid <= (op == OP_RD);
         if (op == OP_RD) begin
            rdata <= mem[addr];
         end
      end
   end
endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
// Pipelined synchronous SRAM with zero bus turnaround between reads and writes.
module nbt_sram #(
   parameter int ADDR_W = 10,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clk_en_n,
   input  logic                            sel1_n,
   input  logic                            sel2,
   input  logic                            sel3_n,
   input  logic                            ld_n,
   input  logic                            wr_n,
   input  logic [NBYTES-1:0]               byte_en_n,
   input  logic [ADDR_W-1:0]               addr,
   input  logic                            order_il,
   input  logic                            oe_n,
   input  logic [NBYTES*(BYTE_W+1)-1:0]    wdata,
   output logic [NBYTES*(BYTE_W+1)-1:0]    rdata,
   output logic                            rdata_oe
);
   localparam int WORD_W = NBYTES * (BYTE_W + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("nbt_sram: ADDR_W must cover the two burst bits");
      end
      if (NBYTES < 1 || BYTE_W < 1) begin : g_bad_lane
         $error("nbt_sram: lane count and width must be positive");
      end
   endgenerate

   logic                en;
   logic                sel;
   nbt_pkg::op_e        cmd_op;
   logic [ADDR_W-1:0]   cmd_addr;
   logic [NBYTES-1:0]   cmd_be_n;
   logic [WORD_W-1:0]   rd_word;
   logic                rd_valid;

   assign en  = ~clk_en_n;
   assign sel = ~sel1_n & sel2 & ~sel3_n;

   nbt_burst_ctr #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .sel      (sel),
      .ld_n     (ld_n),
      .wr_n     (wr_n),
      .be_n     (byte_en_n),
      .addr     (addr),
      .order_il (order_il),
      .cmd_op   (cmd_op),
      .cmd_addr (cmd_addr),
      .cmd_be_n (cmd_be_n)
   );

   nbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .op       (cmd_op),
      .addr     (cmd_addr),
      .be_n     (cmd_be_n),
      .wdata    (wdata),
      .rdata    (rd_word),
      .rd_valid (rd_valid)
   );

   assign rdata    = rd_word;
   assign rdata_oe = rd_valid & ~oe_n;
endmodule

// File: rtl/nbt_sram_chk.sv
`timescale 1ns/1ps
module nbt_sram_chk #(
   parameter int WORD_W = 36
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clk_en_n,
   input logic               sel1_n,
   input logic               sel2,
   input logic               sel3_n,
   input logic               ld_n,
   input logic               oe_n,
   input nbt_pkg::op_e       cmd_op,
   input logic [WORD_W-1:0]  rdata,
   input logic               rdata_oe
);
   import nbt_pkg::*;

   logic chip_on;
   assign chip_on = ~sel1_n & sel2 & ~sel3_n;

   assert_stall_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(rdata));

   assert_stall_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(cmd_op));

   assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !ld_n && !chip_on) |=> (cmd_op == OP_NOP));

   assert_select_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !ld_n && chip_on) |=> (cmd_op != OP_NOP));

   assert_idle_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && ld_n && cmd_op == OP_NOP) |=> (cmd_op == OP_NOP));

   assert_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && cmd_op != OP_RD) |=> !rdata_oe);

   assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);
endmodule

bind nbt_sram nbt_sram_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .sel1_n   (sel1_n),
   .sel2     (sel2),
   .sel3_n   (sel3_n),
   .ld_n     (ld_n),
   .oe_n     (oe_n),
   .cmd_op   (cmd_op),
   .rdata    (rdata),
   .rdata_oe (rdata_oe)
);

// File: tb/nbt_sram_test.sv
`timescale 1ns/1ps
module nbt_sram_test;
   localparam int AW = 10;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int WW = NB * (BW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic          ld_n = 1'b0, wr_n = 1'b1;
   logic [NB-1:0] byte_en_n = '1;
   logic [AW-1:0] addr = '0;
   logic          order_il = 1'b0;
   logic          oe_n = 1'b0;
   logic [WW-1:0] wdata = '0;
   logic [WW-1:0] rdata;
   logic          rdata_oe;

   always #2.5 clk = ~clk;

   nbt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .ld_n(ld_n), .wr_n(wr_n), .byte_en_n(byte_en_n), .addr(addr),
      .order_il(order_il), .oe_n(oe_n), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference: word store plus one pending access
   logic [WW-1:0] mm [int];
   bit            m_active = 0;
   bit            m_bwr = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_step = '0;
   int            p_op = 0;          // 0 idle, 1 read, 2 write
   logic [AW-1:0] p_addr = '0;
   logic [NB-1:0] p_be = '1;
   bit            e_valid = 0;
   logic [WW-1:0] e_data = '0;

   function automatic logic [WW-1:0] pat(int a, int salt);
      logic [WW-1:0] v;
      v = {4'(a ^ salt), 8'(salt * 7 + 1), 8'(a), 16'(16'hC3A0 + a * 3)};
      return v;
   endfunction

   task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_edge(logic ce_n, logic s1n, logic s2, logic s3n, logic ld,
                             logic wr, logic [NB-1:0] be, logic [AW-1:0] a,
                             logic [WW-1:0] wd);
      logic [WW-1:0] msk;
      logic [WW-1:0] old;
      logic [1:0]    off;
      if (ce_n) return;
      if (p_op == 1) begin
         e_data  = mm[int'(p_addr)];
         e_valid = 1;
      end else if (p_op == 2) begin
         for (int i = 0; i < NB; i++) begin
            msk[i*BW +: BW] = {BW{~p_be[i]}};
            msk[NB*BW + i]  = ~p_be[i];
         end
         old = mm.exists(int'(p_addr)) ? mm[int'(p_addr)] : '0;
         mm[int'(p_addr)] = (old & ~msk) | (wd & msk);
         e_valid = 0;
      end else begin
         e_valid = 0;
      end
      p_be = be;
      if (!ld) begin
         if (!s1n && s2 && !s3n) begin
            m_active = 1; m_base = a; m_step = 0; m_bwr = !wr;
            p_op = wr ? 1 : 2; p_addr = a;
         end else begin
            m_active = 0; p_op = 0;
         end
      end else if (m_active) begin
         m_step = m_step + 2'd1;
         off = order_il ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
         p_addr = {m_base[AW-1:2], off};
         p_op = m_bwr ? 2 : 1;
      end else begin
         p_op = 0;
      end
   endtask

   task automatic step(logic ce_n, logic s1n, logic s2, logic s3n, logic ld, logic wr,
                       logic [NB-1:0] be, logic [AW-1:0] a, logic oe,
                       logic [WW-1:0] wd, string tag);
      clk_en_n = ce_n; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
      ld_n = ld; wr_n = wr; byte_en_n = be; addr = a; oe_n = oe; wdata = wd;
      @(posedge clk);
      model_edge(ce_n, s1n, s2, s3n, ld, wr, be, a, wd);
      #1;
      check(tag, WW'(rdata_oe), WW'(e_valid && !oe));
      if (e_valid) check(tag, rdata, e_data);
   endtask

   // selected, enabled, outputs on
   task automatic cyc(logic ld, logic wr, logic [NB-1:0] be, logic [AW-1:0] a,
                      logic [WW-1:0] wd, string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, ld, wr, be, a, 1'b0, wd, tag);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11", WW'(rdata_oe), '0);
      rst_n = 1'b1;

      // R4 R5: back-to-back writes then immediate reads
      cyc(0, 0, 4'b0000, 10, '0, "R4");
      cyc(0, 0, 4'b0000, 11, pat(10, 1), "R4");
      cyc(0, 1, 4'b0000, 11, pat(11, 1), "R5");
      cyc(0, 1, 4'b0000, 10, '0, "R5");
      cyc(0, 1, 4'b0000, 11, '0, "R3");
      cyc(0, 0, 4'b0000, 12, '0, "R3");
      cyc(0, 1, 4'b0000, 12, pat(12, 2), "R5");
      cyc(0, 1, 4'b0000, 10, '0, "R5");

      // R4: lanes 0 and 2 only (bits 7:0, 23:16, parity 32 and 34)
      cyc(0, 0, 4'b1010, 10, '0, "R4");
      cyc(0, 1, 4'b0000, 10, {WW{1'b1}}, "R4");
      cyc(0, 1, 4'b0000, 11, '0, "R4");

      // R6: linear write burst from offset 2, then linear read with wrap
      order_il = 1'b0;
      cyc(0, 0, 4'b0000, 6, '0, "R6");
      cyc(1, 1, 4'b0000, 0, pat(6, 3), "R6");
      cyc(1, 0, 4'b0000, 0, pat(7, 3), "R6");
      cyc(1, 1, 4'b0000, 0, pat(4, 3), "R6");
      cyc(0, 1, 4'b0000, 6, pat(5, 3), "R6");
      for (int k = 0; k < 5; k++) cyc(1, 0, 4'b0000, 0, '0, "R6");

      // R7: interleaved read from offset 1, interleaved write from offset 3
      order_il = 1'b1;
      cyc(0, 1, 4'b0000, 5, '0, "R7");
      for (int k = 0; k < 4; k++) cyc(1, 1, 4'b0000, 0, '0, "R7");
      cyc(0, 0, 4'b0000, 7, '0, "R7");
      for (int k = 0; k < 3; k++) cyc(1, 1, 4'b0000, 0, pat(100 + k, 4), "R7");
      cyc(0, 1, 4'b0000, 4, pat(103, 4), "R7");
      order_il = 1'b0;
      for (int k = 0; k < 3; k++) cyc(1, 1, 4'b0000, 0, '0, "R7");

      // R1 R10 R8: each select wrong, then advance-writes from idle
      step(0, 1, 1, 0, 0, 0, 4'b0000, 4, 0, '0, "R1");
      step(0, 0, 0, 0, 0, 0, 4'b0000, 5, 0, '0, "R1");
      step(0, 0, 1, 1, 0, 0, 4'b0000, 6, 0, '0, "R1");
      step(0, 0, 1, 0, 1, 0, 4'b0000, 7, 0, {WW{1'b1}}, "R10");
      step(0, 0, 1, 0, 1, 0, 4'b0000, 7, 0, {WW{1'b1}}, "R10");
      cyc(0, 1, 4'b0000, 4, {WW{1'b1}}, "R8");
      cyc(0, 1, 4'b0000, 7, '0, "R10");
      cyc(0, 1, 4'b0000, 5, '0, "R10");

      // R2: stall between read capture and output, ignored command inside
      cyc(0, 1, 4'b0000, 12, '0, "R2");
      step(1, 0, 1, 0, 0, 0, 4'b0000, 12, 0, {WW{1'b1}}, "R2");
      step(1, 0, 1, 0, 0, 0, 4'b0000, 12, 0, {WW{1'b1}}, "R2");
      cyc(1, 1, 4'b0000, 0, '0, "R2");
      step(1, 0, 1, 0, 0, 0, 4'b0000, 12, 0, {WW{1'b1}}, "R2");
      // stall during a write data phase
      cyc(0, 0, 4'b0000, 20, '0, "R2");
      step(1, 0, 1, 0, 0, 1, 4'b0000, 20, 0, {WW{1'b1}}, "R2");
      cyc(0, 1, 4'b0000, 20, pat(20, 5), "R2");
      cyc(0, 1, 4'b0000, 12, '0, "R2");

      // R9: output enable high during a read output cycle
      cyc(0, 1, 4'b0000, 11, '0, "R9");
      step(0, 0, 1, 0, 0, 1, 4'b0000, 20, 1, '0, "R9");
      cyc(0, 1, 4'b0000, 10, '0, "R9");
      step(0, 0, 1, 0, 0, 1, 4'b0000, 10, 1, '0, "R9");
      cyc(0, 1, 4'b0000, 10, '0, "R3");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule